// File: doc/BRIEF.md
# Configurable Output Macrocell Bank

This block holds the output macrocells of a sum-of-products logic array. Each cell takes the sum term produced for it by the array and passes it to its pin, either through a D flip-flop or straight through. Each cell can also invert the value on its way to the pin. Two configuration bits per cell choose among the four resulting modes. Each cell also returns a feedback signal to the array. In registered mode the feedback is the flip-flop state. In combinatorial mode the feedback is whatever is present on the pin. A cell whose enable term is held false therefore works as a dedicated input.

All cells share one clock, one asynchronous clear term, one synchronous preset term, a power-up reset and a test preload strobe. The clear and preset terms act on the flip-flops and never on the pins directly. The level seen at a pin is the flip-flop state passed through that cell's polarity setting. Preload lets a tester place any state into the registers: while the strobe is high, every pin driver is switched off, and a rising clock edge copies each pin's value into its flip-flop. The pin itself is modelled as three separate signals: a drive value, a drive enable, and the level sensed on the pad. This lets a surrounding model or bench supply its own external drivers.

Top module: `pld_macrocell_bank`

## Requirements
- R1: Per cell, `cfgComb` (0 = unprogrammed, 1 = programmed) selects registered mode when 0 and combinatorial mode when 1. `cfgActHigh` selects an active-low pin when 0 and an active-high pin when 1.
- R2: On every rising clock edge without reset, clear, preload or preset, each flip-flop takes its `sumTerm` bit. In registered mode, `padOut` equals the flip-flop state when `cfgActHigh`=1 and its inverse when `cfgActHigh`=0.
- R3: In combinatorial mode, `padOut` equals `sumTerm` (active-high) or its inverse (active-low) in the same cycle, with no clock involved.
- R4: `fbOut` shows the flip-flop state for a registered cell and the sensed level `padIn` for a combinatorial cell.
- R5: Raising `asyncClr` forces every flip-flop to 0 at once, without a clock edge. An active-low registered pin therefore goes to 1.
- R6: With `syncSet` high at a rising edge, every flip-flop becomes 1.
- R7: When `asyncClr` and `syncSet` are both high at an edge, the flip-flops stay at 0.
- R8: `padOe` follows `oeTerm` while preload is off. A combinatorial cell whose `oeTerm` is 0 feeds the externally driven `padIn` back through `fbOut`.
- R9: While `preloadEn` is high, every `padOe` is 0. A rising edge loads each flip-flop with its raw `padIn` bit, with no polarity inversion. Preload takes precedence over `syncSet` and over the sum term.
- R10: A high `rstPwr` at a rising edge sets every flip-flop to 0, overriding preload and preset. After this reset, all flip-flops read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock, rising edge |
| rstPwr | input | 1 | Power-up reset, synchronous, active high |
| asyncClr | input | 1 | Shared asynchronous clear term, active high |
| syncSet | input | 1 | Shared synchronous preset term, active high |
| preloadEn | input | 1 | Test preload strobe |
| sumTerm | input | CELLS | Sum term for each cell |
| oeTerm | input | CELLS | Pin drive enable term for each cell |
| cfgComb | input | CELLS | Mode bit for each cell: 1 = combinatorial |
| cfgActHigh | input | CELLS | Polarity bit for each cell: 1 = active high |
| padIn | input | CELLS | Level sensed on each pin |
| padOut | output | CELLS | Value each cell drives onto its pin |
| padOe | output | CELLS | Drive enable for each pin |
| fbOut | output | CELLS | Feedback from each cell into the array |

## Verification
Registered results (the sum load, preset, preload and power-up reset) become visible one rising edge after the stimulus is applied. Combinatorial pin values, feedback from the pin and drive enables follow their inputs within the same cycle. Asynchronous clear takes effect at once. The bench changes inputs at the falling edge. It checks combinatorial outputs one time unit after each change. It checks registered results at the falling edge that follows the rising edge which loaded them. A reference state is updated at each rising edge from the inputs held across that edge. The sweep runs through every mode combination of four cells against every sum pattern.

// File: rtl/omc_pkg.sv
package omc_pkg;

  // Source selected for every flip-flop at the next rising edge
  typedef enum logic [1:0] {
    LD_SUM  = 2'd0,
    LD_ONE  = 2'd1,
    LD_PIN  = 2'd2,
    LD_ZERO = 2'd3
  } loadSel_e;

  // Per-cell strobes handed from control to datapath
  typedef struct packed {
    logic regMode;  // flip-flop path to pin, Q to feedback
    logic invert;   // pin is active low
    logic drive;    // pin driver enabled
  } cellStrb_t;

endpackage

// File: rtl/omc_ctrl.sv
module omc_ctrl
  import omc_pkg::*;
#(
  parameter int CELLS = 4
) (
  input  logic                    rstPwr,
  input  logic                    syncSet,
  input  logic                    preloadEn,
  input  logic [CELLS-1:0]        cfgComb,
  input  logic [CELLS-1:0]        cfgActHigh,
  input  logic [CELLS-1:0]        oeTerm,
  output loadSel_e                loadSel,
  output cellStrb_t [CELLS-1:0]   strb
);

  // Shared priority: power-up reset, then preload, then preset, then sum.
  // Asynchronous clear sits above all of these inside the flip-flop.
  always_comb begin
    if (rstPwr)         loadSel = LD_ZERO;
    else if (preloadEn) loadSel = LD_PIN;
    else if (syncSet)   loadSel = LD_ONE;
    else                loadSel = LD_SUM;
  end

  for (genvar c = 0; c < CELLS; c++) begin : g_cfg
    always_comb begin
      strb[c].regMode = ~cfgComb[c];
      strb[c].invert  = ~cfgActHigh[c];
      strb[c].drive   = oeTerm[c] & ~preloadEn;
    end
  end

endmodule

// File: rtl/omc_dpath.sv
module omc_dpath
  import omc_pkg::*;
#(
  parameter int CELLS = 4
) (
  input  logic                    clk,
  input  logic                    asyncClr,
  input  loadSel_e                loadSel,
  input  cellStrb_t [CELLS-1:0]   strb,
  input  logic [CELLS-1:0]        sumTerm,
  input  logic [CELLS-1:0]        padIn,
  output logic [CELLS-1:0]        padOut,
  output logic [CELLS-1:0]        padOe,
  output logic [CELLS-1:0]        fbOut
);

  logic [CELLS-1:0] qState;

  for (genvar c = 0; c < CELLS; c++) begin : g_cell
    logic nextQ;
    logic preInv;

    always_comb begin
      unique case (loadSel)
        LD_SUM:  nextQ = sumTerm[c];
        LD_ONE:  nextQ = 1'b1;
        LD_PIN:  nextQ = padIn[c];
        default: nextQ = 1'b0;
      endcase
    end

    always_ff @(posedge clk or posedge asyncClr) begin
      if (asyncClr) qState[c] <= 1'b0;
      else          qState[c] <= nextQ;
    end

    always_comb begin
      preInv    = strb[c].regMode ? qState[c] : sumTerm[c];
      padOut[c] = preInv ^ strb[c].invert;
      padOe[c]  = strb[c].drive;
      fbOut[c]  = strb[c].regMode ? qState[c] : padIn[c];
    end
  end

endmodule

// File: rtl/pld_macrocell_bank.sv
module pld_macrocell_bank
  import omc_pkg::*;
#(
  parameter int CELLS = 4
) (
  input  logic             clk,
  input  logic             rstPwr,
  input  logic             asyncClr,
  input  logic             syncSet,
  input  logic             preloadEn,
  input  logic [CELLS-1:0] sumTerm,
  input  logic [CELLS-1:0] oeTerm,
  input  logic [CELLS-1:0] cfgComb,
  input  logic [CELLS-1:0] cfgActHigh,
  input  logic [CELLS-1:0] padIn,
  output logic [CELLS-1:0] padOut,
  output logic [CELLS-1:0] padOe,
  output logic [CELLS-1:0] fbOut
);

  loadSel_e              loadSel;
  cellStrb_t [CELLS-1:0] strb;

  omc_ctrl #(.CELLS(CELLS)) ctrl_i (
    .rstPwr     (rstPwr),
    .syncSet    (syncSet),
    .preloadEn  (preloadEn),
    .cfgComb    (cfgComb),
    .cfgActHigh (cfgActHigh),
    .oeTerm     (oeTerm),
    .loadSel    (loadSel),
    .strb       (strb)
  );

  omc_dpath #(.CELLS(CELLS)) dpath_i (
    .clk      (clk),
    .asyncClr (asyncClr),
    .loadSel  (loadSel),
    .strb     (strb),
    .sumTerm  (sumTerm),
    .padIn    (padIn),
    .padOut   (padOut),
    .padOe    (padOe),
    .fbOut    (fbOut)
  );

endmodule

// File: rtl/pld_macrocell_bank_chk.sv
module pld_macrocell_bank_chk #(
  parameter int CELLS = 4
) (
  input logic             clk,
  input logic             rstPwr,
  input logic             asyncClr,
  input logic             syncSet,
  input logic             preloadEn,
  input logic [CELLS-1:0] sumTerm,
  input logic [CELLS-1:0] oeTerm,
  input logic [CELLS-1:0] cfgComb,
  input logic [CELLS-1:0] cfgActHigh,
  input logic [CELLS-1:0] padIn,
  input logic [CELLS-1:0] padOut,
  input logic [CELLS-1:0] padOe,
  input logic [CELLS-1:0] fbOut
);

  p_preload_oe_r9: assert property (@(posedge clk) disable iff (rstPwr)
    preloadEn |-> (padOe == '0));

  p_oe_follow_r8: assert property (@(posedge clk) disable iff (rstPwr)
    !preloadEn |-> (padOe == oeTerm));

  for (genvar c = 0; c < CELLS; c++) begin : g_chk
    p_reg_load_r2: assert property (@(posedge clk) disable iff (rstPwr)
      (!syncSet && !preloadEn && !asyncClr) |=>
        (asyncClr || cfgComb[c] || fbOut[c] == $past(sumTerm[c])));

    p_reg_pol_r1: assert property (@(posedge clk) disable iff (rstPwr)
      !cfgComb[c] |-> (padOut[c] == (cfgActHigh[c] ? fbOut[c] : !fbOut[c])));

    p_comb_out_r3: assert property (@(posedge clk) disable iff (rstPwr)
      cfgComb[c] |-> (padOut[c] == (cfgActHigh[c] ? sumTerm[c] : !sumTerm[c])));

    p_fb_pin_r4: assert property (@(posedge clk) disable iff (rstPwr)
      cfgComb[c] |-> (fbOut[c] == padIn[c]));

    p_clear_r5: assert property (@(posedge clk) disable iff (rstPwr)
      (asyncClr && !cfgComb[c]) |-> (fbOut[c] == 1'b0));

    p_preset_r6: assert property (@(posedge clk) disable iff (rstPwr)
      (syncSet && !preloadEn && !asyncClr) |=>
        (asyncClr || cfgComb[c] || fbOut[c]));

    p_preload_ld_r9: assert property (@(posedge clk) disable iff (rstPwr)
      (preloadEn && !asyncClr) |=>
        (asyncClr || cfgComb[c] || fbOut[c] == $past(padIn[c])));
  end

endmodule

bind pld_macrocell_bank pld_macrocell_bank_chk #(.CELLS(CELLS)) chk_i (
  .clk        (clk),
  .rstPwr     (rstPwr),
  .asyncClr   (asyncClr),
  .syncSet    (syncSet),
  .preloadEn  (preloadEn),
  .sumTerm    (sumTerm),
  .oeTerm     (oeTerm),
  .cfgComb    (cfgComb),
  .cfgActHigh (cfgActHigh),
  .padIn      (padIn),
  .padOut     (padOut),
  .padOe      (padOe),
  .fbOut      (fbOut)
);

// File: tb/pld_macrocell_bank_tb_top.sv
module pld_macrocell_bank_tb_top;
  localparam int CELLS = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rstPwr, asyncClr, syncSet, preloadEn;
  logic [CELLS-1:0] sumTerm, oeTerm, cfgComb, cfgActHigh, padIn;
  logic [CELLS-1:0] padOut, padOe, fbOut;

  pld_macrocell_bank #(.CELLS(CELLS)) dut_i (
    .clk(clk), .rstPwr(rstPwr), .asyncClr(asyncClr), .syncSet(syncSet),
    .preloadEn(preloadEn), .sumTerm(sumTerm), .oeTerm(oeTerm),
    .cfgComb(cfgComb), .cfgActHigh(cfgActHigh), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .fbOut(fbOut)
  );

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;
  logic [CELLS-1:0] qm;  // reference flip-flop state

  task automatic check(string tag, logic [CELLS-1:0] act, logic [CELLS-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic logic [CELLS-1:0] expOut();
    logic [CELLS-1:0] r;
    for (int i = 0; i < CELLS; i++) begin
      logic v;
      v = cfgComb[i] ? sumTerm[i] : qm[i];
      r[i] = cfgActHigh[i] ? v : ~v;
    end
    return r;
  endfunction

  function automatic logic [CELLS-1:0] expFb();
    logic [CELLS-1:0] r;
    for (int i = 0; i < CELLS; i++) r[i] = cfgComb[i] ? padIn[i] : qm[i];
    return r;
  endfunction

  task automatic checkAll(string tag);
    check({tag, " pin value"}, padOut, expOut());
    check({tag, " drive enable"}, padOe, preloadEn ? '0 : oeTerm);
    check({tag, " feedback"}, fbOut, expFb());
  endtask

  task automatic step();
    @(posedge clk);
    for (int i = 0; i < CELLS; i++) begin
      if (asyncClr || rstPwr) qm[i] = 1'b0;
      else if (preloadEn)     qm[i] = padIn[i];
      else if (syncSet)       qm[i] = 1'b1;
      else                    qm[i] = sumTerm[i];
    end
    @(negedge clk);
  endtask

  initial begin
    rstPwr = 1'b1; asyncClr = 1'b0; syncSet = 1'b0; preloadEn = 1'b0;
    sumTerm = '0; oeTerm = '0; cfgComb = '0; cfgActHigh = '0; padIn = '0;
    qm = '0;
    step(); step();
    rstPwr = 1'b0;
    #1;
    checkAll("R10 reset state");
    check("R10 flops low after reset", fbOut, '0);

    // Sweep every mode combination of four cells against every sum pattern
    for (int cfg = 0; cfg < 256; cfg++) begin
      for (int s = 0; s < 16; s++) begin
        cfgComb    = cfg[3:0];
        cfgActHigh = cfg[7:4];
        sumTerm    = s[3:0];
        padIn      = s[3:0] ^ cfg[3:0] ^ 4'b0110;
        oeTerm     = s[3:0] ^ cfg[7:4];
        #1;
        checkAll("R1 R3 R4 R8 same-cycle");
        step();
        checkAll("R1 R2 R4 registered load");
      end
    end

    // Preset with all cells registered, mixed polarity
    cfgComb = '0; cfgActHigh = 4'b0101; sumTerm = '0; syncSet = 1'b1;
    step();
    checkAll("R6 preset");
    check("R6 preset sets flops", fbOut, '1);

    // Asynchronous clear without clock, then clear against preset
    #1 asyncClr = 1'b1; qm = '0;
    #1;
    checkAll("R5 immediate clear");
    check("R5 active-low pins high", padOut, 4'b1010);
    step();
    checkAll("R7 clear beats preset");
    check("R7 flops stay low", fbOut, '0);
    asyncClr = 1'b0; syncSet = 1'b0; sumTerm = 4'b0011;
    step();
    checkAll("R2 load after clear");

    // Preload: drivers off, raw pin value loaded ahead of preset and sum
    sumTerm = 4'b1111; syncSet = 1'b1; preloadEn = 1'b1;
    padIn = 4'b1010; oeTerm = 4'b1111;
    #1;
    check("R9 drivers off", padOe, '0);
    step();
    checkAll("R9 preload");
    check("R9 raw pin loaded", fbOut, 4'b1010);
    preloadEn = 1'b0; syncSet = 1'b0;
    #1;
    checkAll("R9 after preload");

    // Dedicated input: combinatorial cell with enable held false
    cfgComb = '1; oeTerm = '0; padIn = 4'b0110;
    step();
    checkAll("R8 dedicated input");
    check("R8 pin fed back", fbOut, 4'b0110);

    // Power-up reset mid-run overrides preset and preload
    cfgComb = '0; syncSet = 1'b1;
    step();
    check("R6 preset before reset", fbOut, '1);
    rstPwr = 1'b1; preloadEn = 1'b1; padIn = 4'b1111;
    step();
    rstPwr = 1'b0; preloadEn = 1'b0; syncSet = 1'b0;
    #1;
    check("R10 reset overrides", fbOut, '0);
    checkAll("R10 after mid-run reset");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule